// File: doc/BRIEF.md
# Register-Pair Lane Swizzle Unit

This execution unit rearranges 32-bit words between two register pairs. The source pair (RA, RA+1) is seen as four 32-bit lanes named X, Y, Z and W. Each of the four 32-bit slots of the destination pair (RT, RT+1) receives one selected lane, a constant zero, or a constant one. A slot can also be marked as not written. The block decodes a 32-bit instruction word itself. It returns two 64-bit results, one write enable per destination register, and an illegal-instruction flag. An integer variant and a floating-point variant differ only in how the constant one is encoded.

When the source and destination pair differ, every slot that is not targeted is written as zero. When they are the same pair, a slot that is not targeted keeps its old value. The unit is combinational. A parameter adds a registered output stage, which is the default. The surrounding pipeline supplies the current destination values so that kept slots can be merged.

Top module: `swz_pair_unit`

## Requirements
- R1: The opcode is insn[3:0]. The value 4'b0011 selects the integer form and 4'b1011 selects the floating-point form. Any other value raises `illegal`.
- R2: The destination register number is insn[25:21] and the source register number is insn[20:16]. If either number is odd, `illegal` is raised.
- R3: The 12-bit control is insn[15:4]. Slot s takes the 3-bit code at control bits [3s+2:3s]. Code 7 in any slot raises `illegal`.
- R4: When `illegal` is high, `we_lo` and `we_hi` are low, and `res_lo` and `res_hi` equal `dst_lo` and `dst_hi`.
- R5: Codes 0, 1, 2 and 3 copy lane X, Y, Z and W. X is src_hi[63:32], Y is src_hi[31:0], Z is src_lo[63:32] and W is src_lo[31:0]. Slot 0 is res_lo[31:0], slot 1 is res_lo[63:32], slot 2 is res_hi[31:0] and slot 3 is res_hi[63:32].
- R6: Code 4 writes 32'h0. Code 5 writes 32'h00000001 in the integer form and 32'h3F800000 in the floating-point form.
- R7: Code 6 marks a slot as not targeted. If the two register numbers differ, a legal instruction writes every untargeted slot as zero and raises both write enables.
- R8: If the two register numbers are equal, an untargeted slot keeps its `dst` value. A register's write enable is raised only if at least one of its two slots is targeted.
- R9: With differing register numbers, the pattern slot3=6, slot2=6, slot1=X, slot0=Y makes `res_lo` equal to `src_hi` and makes `res_hi` zero.
- R10: With REG_OUT=1, all outputs are registered. They appear on the clock edge after the inputs are presented. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| insn | input | 32 | Instruction word |
| src_lo | input | 64 | Source register RA (lanes Z, W) |
| src_hi | input | 64 | Source register RA+1 (lanes X, Y) |
| dst_lo | input | 64 | Current value of RT |
| dst_hi | input | 64 | Current value of RT+1 |
| res_lo | output | 64 | New value for RT |
| res_hi | output | 64 | New value for RT+1 |
| we_lo | output | 1 | Write enable for RT |
| we_hi | output | 1 | Write enable for RT+1 |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The hardest case to reach is an in-place swizzle where the register numbers are equal and only one register of the pair is targeted. Only this case exercises the keep-old merge and a split write enable. Uniform random register fields would produce it only about once in sixteen draws. The stimulus therefore forces equal source and destination fields on half of the random vectors. It also adds directed patterns that target one register, the other register, or neither.

// File: rtl/swz_pkg.sv
package swz_pkg;
   localparam int INSN_W    = 32;
   localparam int LANE_W    = 32;
   localparam int NSLOT     = 4;
   localparam int NREG      = NSLOT / 2;
   localparam int REG_W     = 2 * LANE_W;
   localparam int SEL_W     = 3;
   localparam int CTRL_W    = NSLOT * SEL_W;
   localparam int OPC_W     = 4;
   localparam int RNUM_W    = 5;
   localparam int RT_LSB    = 21;
   localparam int RA_LSB    = 16;
   localparam int CTRL_LSB  = 4;

   typedef enum logic [SEL_W-1:0] {
      PICK_X    = 3'd0,
      PICK_Y    = 3'd1,
      PICK_Z    = 3'd2,
      PICK_W    = 3'd3,
      PICK_ZERO = 3'd4,
      PICK_ONE  = 3'd5,
      PICK_SKIP = 3'd6,
      PICK_RSVD = 3'd7
   } pick_e;

   localparam logic [LANE_W-1:0] INT_ONE = 32'h0000_0001;
   localparam logic [LANE_W-1:0] FP_ONE  = 32'h3F80_0000;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
   import swz_pkg::*;
#(
   parameter logic [OPC_W-1:0] INT_OPC = 4'b0011,
   parameter logic [OPC_W-1:0] FP_OPC  = 4'b1011
) (
   input  logic [INSN_W-1:0]           insn,
   output logic                        legal,
   output logic                        is_fp,
   output logic                        keep_old,
   output logic [NSLOT-1:0][SEL_W-1:0] sel
);
   logic [OPC_W-1:0]  opc;
   logic [RNUM_W-1:0] rt_num;
   logic [RNUM_W-1:0] ra_num;
   logic [CTRL_W-1:0] ctrl;
   logic [NSLOT-1:0]  rsvd_hit;
   logic              opc_ok;
   logic              unused_top_bits;

   assign opc             = insn[OPC_W-1:0];
   assign rt_num          = insn[RT_LSB +: RNUM_W];
   assign ra_num          = insn[RA_LSB +: RNUM_W];
   assign ctrl            = insn[CTRL_LSB +: CTRL_W];
   assign unused_top_bits = ^insn[INSN_W-1:RT_LSB+RNUM_W];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign sel[s]      = ctrl[s*SEL_W +: SEL_W];
      assign rsvd_hit[s] = (sel[s] == PICK_RSVD);
   end

   assign opc_ok   = (opc == INT_OPC) || (opc == FP_OPC);
   assign is_fp    = (opc == FP_OPC);
   assign keep_old = (rt_num == ra_num);
   assign legal    = opc_ok && !rt_num[0] && !ra_num[0] && !(|rsvd_hit);
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
   import swz_pkg::*;
(
   input  logic [REG_W-1:0]             src_lo,
   input  logic [REG_W-1:0]             src_hi,
   input  logic                         is_fp,
   input  logic [NSLOT-1:0][SEL_W-1:0]  sel,
   output logic [NSLOT-1:0][LANE_W-1:0] word,
   output logic [NSLOT-1:0]             hit
);
   logic [NSLOT-1:0][LANE_W-1:0] lanes;
   logic [LANE_W-1:0]            one_val;

   assign lanes   = {src_hi, src_lo};
   assign one_val = is_fp ? FP_ONE : INT_ONE;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_comb begin
         word[s] = '0;
         hit[s]  = 1'b1;
         case (sel[s])
            PICK_X, PICK_Y, PICK_Z, PICK_W: word[s] = lanes[~sel[s][1:0]];
            PICK_ZERO:                      word[s] = '0;
            PICK_ONE:                       word[s] = one_val;
            default:                        hit[s]  = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/swz_merge.sv
module swz_merge
   import swz_pkg::*;
(
   input  logic [NSLOT-1:0][LANE_W-1:0] word,
   input  logic [NSLOT-1:0]             hit,
   input  logic [REG_W-1:0]             dst_lo,
   input  logic [REG_W-1:0]             dst_hi,
   input  logic                         legal,
   input  logic                         keep_old,
   output logic [REG_W-1:0]             res_lo,
   output logic [REG_W-1:0]             res_hi,
   output logic [NREG-1:0]              we
);
   logic [NSLOT-1:0][LANE_W-1:0] old_w;
   logic [NSLOT-1:0][LANE_W-1:0] out_w;

   assign old_w = {dst_hi, dst_lo};

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_comb begin
         if (!legal)         out_w[s] = old_w[s];
         else if (hit[s])    out_w[s] = word[s];
         else if (keep_old)  out_w[s] = old_w[s];
         else                out_w[s] = '0;
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign we[r] = legal && (!keep_old || (|hit[2*r +: 2]));
   end

   assign {res_hi, res_lo} = out_w;
endmodule

// File: rtl/swz_pair_unit.sv
module swz_pair_unit
   import swz_pkg::*;
#(
   parameter bit               REG_OUT = 1'b1,
   parameter logic [OPC_W-1:0] INT_OPC = 4'b0011,
   parameter logic [OPC_W-1:0] FP_OPC  = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn,
   input  logic [REG_W-1:0]  src_lo,
   input  logic [REG_W-1:0]  src_hi,
   input  logic [REG_W-1:0]  dst_lo,
   input  logic [REG_W-1:0]  dst_hi,
   output logic [REG_W-1:0]  res_lo,
   output logic [REG_W-1:0]  res_hi,
   output logic              we_lo,
   output logic              we_hi,
   output logic              illegal
);
   if (INT_OPC == FP_OPC) begin : g_chk_opc
      $error("swz_pair_unit: integer and float opcodes must differ");
   end
   if (NSLOT != 4 || LANE_W != 32) begin : g_chk_shape
      $error("swz_pair_unit: four 32-bit lanes are required");
   end

   logic                         legal_c, is_fp_c, keep_c;
   logic [NSLOT-1:0][SEL_W-1:0]  sel_c;
   logic [NSLOT-1:0][LANE_W-1:0] word_c;
   logic [NSLOT-1:0]             hit_c;
   logic [REG_W-1:0]             res_lo_c, res_hi_c;
   logic [NREG-1:0]              we_c;

   swz_decode #(.INT_OPC(INT_OPC), .FP_OPC(FP_OPC)) u_dec (
      .insn(insn), .legal(legal_c), .is_fp(is_fp_c),
      .keep_old(keep_c), .sel(sel_c)
   );

   swz_lane_mux u_mux (
      .src_lo(src_lo), .src_hi(src_hi), .is_fp(is_fp_c),
      .sel(sel_c), .word(word_c), .hit(hit_c)
   );

   swz_merge u_merge (
      .word(word_c), .hit(hit_c), .dst_lo(dst_lo), .dst_hi(dst_hi),
      .legal(legal_c), .keep_old(keep_c),
      .res_lo(res_lo_c), .res_hi(res_hi_c), .we(we_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_lo  <= '0;
            res_hi  <= '0;
            we_lo   <= 1'b0;
            we_hi   <= 1'b0;
            illegal <= 1'b0;
         end else begin
            res_lo  <= res_lo_c;
            res_hi  <= res_hi_c;
            we_lo   <= we_c[0];
            we_hi   <= we_c[1];
            illegal <= !legal_c;
         end
      end

      p_quiet_on_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
         illegal |-> (!we_lo && !we_hi));

      p_odd_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(insn[RT_LSB] | insn[RA_LSB])) |-> illegal);

      p_bad_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(insn[OPC_W-1:0] != INT_OPC && insn[OPC_W-1:0] != FP_OPC))
         |-> illegal);

      p_zero_fill_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !illegal &&
          $past(insn[RT_LSB +: RNUM_W] != insn[RA_LSB +: RNUM_W])) |-> (we_lo && we_hi));

      p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!rst_n) |-> (!we_lo && !we_hi && !illegal && res_lo == '0 && res_hi == '0));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign res_lo  = res_lo_c;
      assign res_hi  = res_hi_c;
      assign we_lo   = we_c[0];
      assign we_hi   = we_c[1];
      assign illegal = !legal_c;
   end
endmodule

// File: tb/tb_swz_pair_unit.sv
`timescale 1ns/1ps
module tb_swz_pair_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] src_lo = '0, src_hi = '0, dst_lo = '0, dst_hi = '0;
   logic [63:0] res_lo, res_hi;
   logic        we_lo, we_hi, illegal;

   int checks = 0;
   int errors = 0;

   logic [63:0] e_lo, e_hi;
   logic        e_we_lo, e_we_hi, e_ill;

   always #2.5 clk = ~clk;

   swz_pair_unit dut (
      .clk(clk), .rst_n(rst_n), .insn(insn),
      .src_lo(src_lo), .src_hi(src_hi), .dst_lo(dst_lo), .dst_hi(dst_hi),
      .res_lo(res_lo), .res_hi(res_hi), .we_lo(we_lo), .we_hi(we_hi),
      .illegal(illegal)
   );

   function automatic logic [31:0] mk(int rt, int ra, int s3, int s2, int s1, int s0, logic [3:0] opc);
      logic [31:0] v;
      v = '0;
      v[25:21] = rt[4:0];
      v[20:16] = ra[4:0];
      v[15:13] = s3[2:0];
      v[12:10] = s2[2:0];
      v[9:7]   = s1[2:0];
      v[6:4]   = s0[2:0];
      v[3:0]   = opc;
      return v;
   endfunction

   // Behavioural reference built from the requirement text
   task automatic model();
      int          rt, ra, code;
      bit          fp, bad, any0, any1;
      logic [31:0] lane [4];
      logic [31:0] prev [4];
      logic [31:0] outw [4];
      rt = int'(insn[25:21]);
      ra = int'(insn[20:16]);
      fp = (insn[3:0] == 4'b1011);
      bad = !(insn[3:0] == 4'b0011 || fp) || (rt % 2 != 0) || (ra % 2 != 0);
      lane[0] = src_hi[63:32]; lane[1] = src_hi[31:0];
      lane[2] = src_lo[63:32]; lane[3] = src_lo[31:0];
      prev[0] = dst_lo[31:0];  prev[1] = dst_lo[63:32];
      prev[2] = dst_hi[31:0];  prev[3] = dst_hi[63:32];
      any0 = 0; any1 = 0;
      for (int s = 0; s < 4; s++) begin
         code = int'((insn >> (4 + 3*s)) & 32'd7);
         if (code == 7) bad = 1;
         if (code <= 3) outw[s] = lane[code];
         else if (code == 4) outw[s] = 32'h0;
         else if (code == 5) outw[s] = fp ? 32'h3F80_0000 : 32'h1;
         else outw[s] = (rt == ra) ? prev[s] : 32'h0;
         if (code <= 5) begin
            if (s < 2) any0 = 1; else any1 = 1;
         end
      end
      if (bad) begin
         e_lo = dst_lo; e_hi = dst_hi; e_we_lo = 0; e_we_hi = 0; e_ill = 1;
      end else begin
         e_lo = {outw[1], outw[0]};
         e_hi = {outw[3], outw[2]};
         e_we_lo = (rt != ra) || any0;
         e_we_hi = (rt != ra) || any1;
         e_ill = 0;
      end
   endtask

   task automatic compare(string tag);
      checks++;
      if (res_lo !== e_lo || res_hi !== e_hi || we_lo !== e_we_lo ||
          we_hi !== e_we_hi || illegal !== e_ill) begin
         errors++;
         $display("FAIL %s: got lo=%h hi=%h we=%b%b ill=%b expected lo=%h hi=%h we=%b%b ill=%b",
                  tag, res_lo, res_hi, we_hi, we_lo, illegal,
                  e_lo, e_hi, e_we_hi, e_we_lo, e_ill);
      end
   endtask

   task automatic expect64(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge: present inputs, wait for the capture edge, sample at the next falling edge
   task automatic apply(logic [31:0] i, logic [63:0] sh, logic [63:0] sl,
                        logic [63:0] dh, logic [63:0] dl, string tag);
      insn = i; src_hi = sh; src_lo = sl; dst_hi = dh; dst_lo = dl;
      model();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam logic [3:0] OI = 4'b0011;
   localparam logic [3:0] OF = 4'b1011;
   localparam logic [63:0] SH = 64'h1111_AAAA_2222_BBBB;
   localparam logic [63:0] SL = 64'h3333_CCCC_4444_DDDD;
   localparam logic [63:0] DH = 64'h5555_EEEE_6666_FFFF;
   localparam logic [63:0] DL = 64'h7777_0101_8888_0202;

   initial begin
      rst_n = 1'b0;
      insn = mk(2, 4, 0, 1, 2, 3, OI);
      src_hi = SH; src_lo = SL; dst_hi = DH; dst_lo = DL;
      repeat (4) @(negedge clk);
      // R10: outputs cleared while reset is held even with a legal instruction presented
      checks++;
      if (res_lo !== '0 || res_hi !== '0 || we_lo !== 1'b0 || we_hi !== 1'b0 || illegal !== 1'b0) begin
         errors++;
         $display("FAIL R10 reset: got lo=%h hi=%h we=%b%b ill=%b expected all zero",
                  res_lo, res_hi, we_hi, we_lo, illegal);
      end
      rst_n = 1'b1;

      // R9: "..XY" copies RA+1 into RT and clears RT+1
      apply(mk(4, 8, 6, 6, 0, 1, OI), SH, SL, DH, DL, "R9 pattern");
      expect64("R9 res_lo", res_lo, SH);
      expect64("R9 res_hi", res_hi, 64'h0);

      // R5: identity and reversed lane orders
      apply(mk(2, 6, 0, 1, 2, 3, OI), SH, SL, DH, DL, "R5 identity");
      expect64("R5 identity hi", res_hi, SH);
      apply(mk(2, 6, 3, 2, 1, 0, OI), SH, SL, DH, DL, "R5 reversed");
      expect64("R5 reversed lo", res_lo, {SH[31:0], SH[63:32]});

      // R6: constants in both forms
      apply(mk(0, 2, 5, 4, 5, 4, OI), SH, SL, DH, DL, "R6 int constants");
      expect64("R6 int one", res_hi, 64'h0000_0001_0000_0000);
      apply(mk(0, 2, 5, 4, 4, 5, OF), SH, SL, DH, DL, "R6 fp constants");
      expect64("R6 fp one lo", res_lo, 64'h0000_0000_3F80_0000);
      expect64("R6 fp one hi", res_hi, 64'h3F80_0000_0000_0000);

      // R7: nothing targeted with different registers zeroes both and writes both
      apply(mk(10, 12, 6, 6, 6, 6, OF), SH, SL, DH, DL, "R7 all skipped");
      expect64("R7 zero lo", res_lo, 64'h0);

      // R8: in place, keep old slots and split write enables
      apply(mk(6, 6, 6, 6, 6, 6, OI), SH, SL, DH, DL, "R8 none targeted");
      apply(mk(6, 6, 6, 6, 0, 6, OI), SH, SL, DH, DL, "R8 lo only");
      expect64("R8 merged lo", res_lo, {SH[63:32], DL[31:0]});
      apply(mk(6, 6, 6, 3, 6, 6, OF), SH, SL, DH, DL, "R8 hi only");
      expect64("R8 kept hi word", res_hi, {DH[63:32], SL[31:0]});

      // R2, R1, R3 illegal cases, each with R4 quiet outputs
      apply(mk(3, 4, 0, 1, 2, 3, OI), SH, SL, DH, DL, "R2 odd RT / R4");
      apply(mk(4, 5, 0, 1, 2, 3, OF), SH, SL, DH, DL, "R2 odd RA / R4");
      apply(mk(4, 8, 0, 1, 2, 3, 4'b0000), SH, SL, DH, DL, "R1 opcode 0000 / R4");
      apply(mk(4, 8, 0, 1, 2, 3, 4'b0111), SH, SL, DH, DL, "R1 opcode 0111 / R4");
      apply(mk(4, 8, 0, 7, 2, 3, OI), SH, SL, DH, DL, "R3 reserved code / R4");
      apply(mk(4, 4, 7, 6, 6, 6, OF), SH, SL, DH, DL, "R3 reserved in place / R4");

      // Random sweep covering R5, R6, R7, R8 with forced in-place half
      for (int n = 0; n < 400; n++) begin
         logic [31:0] ri;
         int rt, ra;
         ri = $urandom;
         rt = int'($urandom_range(0, 15)) * 2;
         ra = (n % 2 == 0) ? rt : int'($urandom_range(0, 15)) * 2;
         if (n % 10 == 9) rt = rt | 1;
         ri[25:21] = rt[4:0];
         ri[20:16] = ra[4:0];
         if (n % 13 != 0) ri[3:0] = (n % 3 == 0) ? OF : OI;
         for (int s = 0; s < 4; s++) begin
            if (ri[4 + 3*s +: 3] == 3'd7 && (n % 7 != 0)) ri[4 + 3*s +: 3] = 3'd6;
         end
         apply(ri, {$urandom, $urandom}, {$urandom, $urandom},
               {$urandom, $urandom}, {$urandom, $urandom}, "R5/R6/R7/R8 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule